// File: doc/BRIEF.md
# I2C Target with Fixed Address Match

This block is the target side of a two-wire serial bus. It samples the clock and data lines through a small synchroniser. From the synchronised lines it detects start, repeated-start and stop conditions. After each start it assembles the first byte, which holds a 7-bit address and a direction bit, and compares the address with a parameter. When the address matches, the block acknowledges it.

The block then runs in one of two directions. In a write, it collects bytes from the controller, presents each byte with a one-cycle valid pulse, and acknowledges it. In a read, it takes each byte from a data input when it signals a load, shifts the byte out, and watches for the controller's acknowledge. The block only pulls the data line low, through an active-low enable. It never drives the clock line. It does not stretch the clock.

Top module: `i2c_addr_target`

## Requirements
- R1: After reset, `sda_oe_n` is 1 (line released), `rx_valid` is 0 and `selected` is 0.
- R2: The first byte after a start carries the address in bits 7..1, most significant bit first, and the direction in bit 0 (1 = controller reads). If the address equals `TARGET_ADDR`, the block pulls SDA low through the whole ninth clock high period and `selected` becomes 1.
- R3: If any address bit differs, SDA stays high during the ninth clock. Until the next start, the block acknowledges nothing and raises no `rx_valid`.
- R4: In a write, each data byte is taken in most significant bit first. It appears on `rx_data` with a one-cycle `rx_valid` pulse. SDA is then held low, stable across the whole ninth clock high period.
- R5: In a read, `tx_data` is sampled in the cycle `tx_load` pulses, after the falling clock edge that ends the previous acknowledge. It is shifted out most significant bit first: a 0 bit pulls SDA low and a 1 bit releases it. The block releases SDA during the ninth clock.
- R6: A low acknowledge from the controller after a sent byte makes the block load and send the next byte.
- R7: A high (not-acknowledged) bit from the controller after a sent byte makes the block release SDA and drop `selected` before the next clock falling edge.
- R8: A repeated start in any state, whether addressed, unaddressed or mid-transfer, restarts address reception at once. The new address and direction take effect without a stop in between.
- R9: A stop at any point, including in the middle of a byte, returns the block to idle with SDA released and `selected` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen on the pad |
| sda_i | input | 1 | Bus data line as seen on the pad |
| sda_oe_n | output | 1 | Active-low enable to pull SDA low |
| tx_data | input | 8 | Byte to send when the controller reads |
| tx_load | output | 1 | One-cycle pulse when `tx_data` is sampled |
| rx_data | output | 8 | Last byte written by the controller |
| rx_valid | output | 1 | One-cycle pulse marking `rx_data` as new |
| selected | output | 1 | High while addressed, past the address byte |

## Verification
The bench builds the block with `TARGET_ADDR` = 7'h2D and two synchroniser stages. The address has alternating bit groups, so the bench can probe neighbours that differ only in the least or only in the most significant bit. Each neighbour must fail to match. The SCL quarter period of six system cycles exceeds the synchroniser and detection latency, so every data change the target makes lands while SCL is low. This lets the bench sample the acknowledge both early and late in the high phase. The source of read bytes changes its value after every load, so a missed or extra load shows up as a wrong byte.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_TX_WAIT
  } i2ct_state_e;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_chain, sda_chain;
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_chain <= '1;
      sda_chain <= '1;
      scl_d     <= 1'b1;
      sda_d     <= 1'b1;
    end else begin
      scl_chain <= {scl_chain[SYNC_STAGES-2:0], scl_i};
      sda_chain <= {sda_chain[SYNC_STAGES-2:0], sda_i};
      scl_d     <= scl_chain[SYNC_STAGES-1];
      sda_d     <= sda_chain[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_chain[SYNC_STAGES-1];
  assign sda_s     = sda_chain[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2ct_byte_shift.sv
module i2ct_byte_shift
  import i2ct_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_in,
  input  logic              shift_out,
  input  logic              bit_in,
  input  logic [BYTE_W-1:0] load_val,
  output logic [BYTE_W-1:0] value
);
  logic [BYTE_W-1:0] value_n;

  always_comb begin
    value_n = value;
    if (load)           value_n = load_val;
    else if (shift_in)  value_n = {value[BYTE_W-2:0], bit_in};
    else if (shift_out) value_n = {value[BYTE_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) value <= '0;
    else        value <= value_n;
  end
endmodule

// File: rtl/i2c_addr_target.sv
module i2c_addr_target
  import i2ct_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TARGET_ADDR = 7'h2D,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_n,
  input  logic [BYTE_W-1:0] tx_data,
  output logic              tx_load,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              selected
);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_BYTE = CNT_W'(BYTE_W);

  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

  i2ct_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2ct_state_e       state, state_n;
  logic [CNT_W-1:0]  cnt, cnt_n;
  logic              oe_n_q, oe_n_n;
  logic              rw_q, rw_n;
  logic              rxv_q, rxv_n;
  logic              ld, sh_in, sh_out;
  logic [BYTE_W-1:0] sreg;

  i2ct_byte_shift u_shift (
    .clk(clk), .rst_n(rst_sync_n), .load(ld), .shift_in(sh_in),
    .shift_out(sh_out), .bit_in(sda_s), .load_val(tx_data), .value(sreg)
  );

  always_comb begin
    state_n = state;
    cnt_n   = cnt;
    oe_n_n  = oe_n_q;
    rw_n    = rw_q;
    rxv_n   = 1'b0;
    ld      = 1'b0;
    sh_in   = 1'b0;
    sh_out  = 1'b0;
    if (stop_det) begin
      state_n = ST_IDLE;
      oe_n_n  = 1'b1;
    end else if (start_det) begin
      state_n = ST_ADDR;
      cnt_n   = '0;
      oe_n_n  = 1'b1;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR: begin
          if (scl_rise) begin
            sh_in = 1'b1;
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL_BYTE) begin
            if (sreg[BYTE_W-1:1] == TARGET_ADDR) begin
              state_n = ST_ADDR_ACK;
              oe_n_n  = 1'b0;
              rw_n    = sreg[0];
            end else begin
              state_n = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK, ST_TX_WAIT: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (state == ST_TX_WAIT || rw_q) begin
              ld      = 1'b1;
              state_n = ST_TX;
              oe_n_n  = tx_data[BYTE_W-1];
            end else begin
              state_n = ST_RX;
              oe_n_n  = 1'b1;
            end
          end
        end
        ST_RX: begin
          if (scl_rise) begin
            sh_in = 1'b1;
            cnt_n = cnt + 1'b1;
          end else if (scl_fall && cnt == FULL_BYTE) begin
            rxv_n   = 1'b1;
            state_n = ST_RX_ACK;
            oe_n_n  = 1'b0;
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            state_n = ST_RX;
            cnt_n   = '0;
            oe_n_n  = 1'b1;
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt == LAST_BIT) begin
              state_n = ST_TX_ACK;
              oe_n_n  = 1'b1;
            end else begin
              sh_out = 1'b1;
              cnt_n  = cnt + 1'b1;
              oe_n_n = sreg[BYTE_W-2];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) state_n = sda_s ? ST_IDLE : ST_TX_WAIT;
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      oe_n_q <= 1'b1;
      rw_q   <= 1'b0;
      rxv_q  <= 1'b0;
    end else begin
      state  <= state_n;
      cnt    <= cnt_n;
      oe_n_q <= oe_n_n;
      rw_q   <= rw_n;
      rxv_q  <= rxv_n;
    end
  end

  assign sda_oe_n = oe_n_q;
  assign rx_valid = rxv_q;
  assign rx_data  = sreg;
  assign tx_load  = ld;
  assign selected = (state != ST_IDLE) && (state != ST_ADDR);
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic start_det,
  input logic stop_det,
  input logic sda_oe_n,
  input logic rx_valid,
  input logic tx_load,
  input logic selected
);
  // R4
  rxv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R4
  rxv_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (selected && !sda_oe_n));

  // R9
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (sda_oe_n && !selected));

  // R8
  restart_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (sda_oe_n && !selected));

  // R5
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_n) |-> !scl_s);

  // R5
  load_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |-> (!scl_s && selected));
endmodule

bind i2c_addr_target i2ct_checker u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_det(start_det),
  .stop_det(stop_det), .sda_oe_n(sda_oe_n), .rx_valid(rx_valid),
  .tx_load(tx_load), .selected(selected)
);

// File: tb/sim_i2c_addr_target.sv
module sim_i2c_addr_target;
  localparam logic [6:0] ADDR = 7'h2D;
  localparam int Q = 6;

  logic clk, rst_n, m_scl, m_sda, sda_line;
  logic sda_oe_n, tx_load, rx_valid, selected;
  logic [7:0] tx_data, rx_data;
  int n_chk, n_bad, tx_idx, rd_k;
  logic [7:0] exp_q[$];
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign sda_line = m_sda & sda_oe_n;

  function automatic logic [7:0] pat(int k);
    return 8'(8'h96 + 8'h3B * k);
  endfunction

  assign tx_data = pat(tx_idx);
  always @(posedge clk) if (tx_load) tx_idx <= tx_idx + 1;

  i2c_addr_target #(.TARGET_ADDR(ADDR), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .sda_oe_n(sda_oe_n), .tx_data(tx_data), .tx_load(tx_load),
    .rx_data(rx_data), .rx_valid(rx_valid), .selected(selected)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected write bytes as rx_valid appears (R4, R3)
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) chk(0, "R3 unexpected rx_valid", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R4 rx byte", rx_data, e);
      end
    end
  end

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
  endtask

  task automatic put_bit(logic b);
    m_sda = b; wq(); m_scl = 1'b1; wq(); wq(); m_scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b, output logic stable_low);
    logic first;
    m_sda = 1'b1; wq(); m_scl = 1'b1; repeat (2) @(negedge clk);
    first = sda_line; wq();
    b = sda_line; stable_low = (first == 1'b0) && (b == 1'b0);
    repeat (Q - 2) @(negedge clk); m_scl = 1'b0; wq();
  endtask

  task automatic write_byte(logic [7:0] v, output logic ack, output logic held);
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(ack, held);
  endtask

  task automatic read_byte(logic nack, output logic [7:0] v, output logic rel);
    logic b, h;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, h);
      v[i] = b;
    end
    m_sda = nack; wq(); m_scl = 1'b1; wq();
    rel = sda_oe_n; wq(); m_scl = 1'b0; wq();
  endtask

  task automatic addr_phase(logic [6:0] a, logic rd, logic exp_ack, string req);
    logic ack, held;
    write_byte({a, rd}, ack, held);
    chk(ack == ~exp_ack, req, ack, ~exp_ack);
    if (exp_ack) chk(held, {req, " ack held"}, held, 1);
  endtask

  task automatic wr_data(logic [7:0] v, bit expect_ack);
    logic ack, held;
    if (expect_ack) exp_q.push_back(v);
    write_byte(v, ack, held);
    if (expect_ack) begin
      chk(ack == 1'b0, "R4 data ack", ack, 0);
      chk(held, "R4 ack stable over high", held, 1);
    end else chk(ack == 1'b1, "R3 data ignored", ack, 1);
  endtask

  task automatic rd_data(logic nack);
    logic [7:0] v; logic rel;
    read_byte(nack, v, rel);
    chk(v == pat(rd_k), "R5 R6 read byte", v, pat(rd_k));
    chk(rel == 1'b1, "R5 release in ninth clock", rel, 1);
    rd_k++;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic b;
    n_chk = 0; n_bad = 0; tx_idx = 0; rd_k = 0; done = 0;
    m_scl = 1'b1; m_sda = 1'b1; rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1
    chk(sda_oe_n == 1'b1, "R1 sda released", sda_oe_n, 1);
    chk(rx_valid == 1'b0, "R1 no valid", rx_valid, 0);
    chk(selected == 1'b0, "R1 not selected", selected, 0);

    // R2 R4 write sequence
    bus_start();
    addr_phase(ADDR, 1'b0, 1'b1, "R2 write addr ack");
    chk(selected == 1'b1, "R2 selected", selected, 1);
    wr_data(8'hA5, 1); wr_data(8'h3C, 1); wr_data(8'h00, 1); wr_data(8'hFF, 1);
    bus_stop();
    // R9
    chk(selected == 1'b0 && sda_oe_n == 1'b1, "R9 idle after stop", selected, 0);

    // R3 mismatch in LSB and MSB
    bus_start();
    addr_phase(ADDR ^ 7'h01, 1'b0, 1'b0, "R3 lsb mismatch nack");
    wr_data(8'h55, 0);
    chk(selected == 1'b0, "R3 not selected", selected, 0);
    bus_stop();
    bus_start();
    addr_phase(ADDR ^ 7'h40, 1'b1, 1'b0, "R3 msb mismatch nack");
    bus_stop();

    // R5 R6 R7 read sequence
    bus_start();
    addr_phase(ADDR, 1'b1, 1'b1, "R2 read addr ack");
    rd_data(1'b0); rd_data(1'b0); rd_data(1'b1);
    // R7
    chk(selected == 1'b0, "R7 deselect on nack", selected, 0);
    chk(sda_oe_n == 1'b1, "R7 release on nack", sda_oe_n, 1);
    bus_stop();

    // R8 repeated start write then read
    bus_start();
    addr_phase(ADDR, 1'b0, 1'b1, "R8 first addr");
    wr_data(8'h81, 1);
    bus_start();
    addr_phase(ADDR, 1'b1, 1'b1, "R8 restart read addr");
    rd_data(1'b1);
    bus_stop();
    // R8 restart after mismatch
    bus_start();
    addr_phase(7'h11, 1'b0, 1'b0, "R8 wrong addr nack");
    bus_start();
    addr_phase(ADDR, 1'b0, 1'b1, "R8 restart after mismatch");
    wr_data(8'h6E, 1);
    bus_stop();

    // R9 stop in middle of a byte
    bus_start();
    addr_phase(ADDR, 1'b0, 1'b1, "R9 addr");
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    chk(selected == 1'b0, "R9 stop mid byte", selected, 0);
    bus_start();
    addr_phase(ADDR, 1'b0, 1'b1, "R9 next transfer");
    wr_data(8'h24, 1);
    bus_stop();

    b = 1'b0;
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 all bytes seen", exp_q.size(), 0);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule